// File: doc/BRIEF.md
# Multi-Core OR-Merge Remote Write Fabric

This fabric connects a set of cores so that each core can write into the local lookup RAM of any chosen group of cores, including its own. Every source core drives one write strobe per target core, plus one shared address word and one shared data word. At each target, a source's address and data are passed on only when that source strobes the target, and only when the target's allow mask admits that source. All admitted contributions are then bitwise ORed into a single write on the target RAM's second port.

There is no arbitration. Sources that write different targets in the same cycle do not disturb each other. Sources that strobe the same target in the same cycle produce one combined write: the OR of their data lands at the OR of their addresses. A sticky per-target event bit records that some admitted write arrived. It does not record which source made it. Each RAM also has a simple registered read port so that its contents can be inspected.

Top module: `lutfab_top`

## Requirements
- R1: When source s sets strobe bit `src_stb[s*N_CORES+t]` and target t admits s, the word on `src_data[s*DATA_W +: DATA_W]` is written at `src_addr[s*ADDR_W +: ADDR_W]` in target t's RAM on the clock edge that samples the strobe. Presenting an address on `rd_addr[t*ADDR_W +: ADDR_W]` returns the stored word on `rd_data` after one clock edge. A read and a write to the same address on the same edge return the old word.
- R2: A source may strobe any subset of targets in one cycle, and every selected target receives the same address and data.
- R3: Writes from different sources to different targets in the same cycle each land intact.
- R4: When two or more admitted sources strobe one target in the same cycle, exactly one write takes place: the OR of their data is stored at the OR of their addresses. For example, data 2 to address 2 merged with data 1 to address 1 stores 3 at address 3.
- R5: A core may write its own RAM through this path, because source t strobing target t behaves like any other source.
- R6: `evt_flag[t]` becomes 1 after any edge at which target t accepts a write. It stays at 1 until `evt_clr[t]` clears it. When a write and a clear arrive in the same cycle, the write wins.
- R7: Bit s of target t's allow mask admits source s. A target's allow mask is loaded from `mask_val[t*N_CORES +: N_CORES]` on the edge where `mask_we[t]` is high, and it governs strobes from the following cycle on. A blocked strobe changes neither the RAM nor the event flag.
- R8: After reset, every event flag is 0 and every allow mask is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_stb | input | N_CORES*N_CORES | Strobe from source s to target t at bit s*N_CORES+t |
| src_addr | input | N_CORES*ADDR_W | Write address of each source |
| src_data | input | N_CORES*DATA_W | Write data of each source |
| mask_we | input | N_CORES | Load enable for each target's allow mask |
| mask_val | input | N_CORES*N_CORES | New allow mask per target, bit s admits source s |
| evt_clr | input | N_CORES | Clears each target's event flag |
| evt_flag | output | N_CORES | Sticky remote-write event per target |
| rd_addr | input | N_CORES*ADDR_W | Inspection read address per target |
| rd_data | output | N_CORES*DATA_W | Registered inspection read data per target |

## Verification
The bench builds the fabric with its defaults: 16 cores, a 7-bit address (128 words per RAM) and 32-bit data. With all 16 sources and all 16 targets in place, the bench can broadcast to every RAM at once, write all targets in a rotation during a single cycle, and pile several sources onto one target. The shorter RAM keeps a full fill and the random traffic cheap while leaving address overlaps in an OR merge frequent. Directed collisions, self writes, mask blocking and clear-versus-write races are followed by random traffic. A behavioural model tracks every RAM word and flag and is compared on every clock.

// File: rtl/lutfab_pkg.sv
package lutfab_pkg;
    localparam int unsigned DEF_CORES  = 16;
    localparam int unsigned DEF_ADDR_W = 7;
    localparam int unsigned DEF_DATA_W = 32;
endpackage

// File: rtl/lutfab_merge.sv
module lutfab_merge #(
    parameter int unsigned N_CORES = lutfab_pkg::DEF_CORES,
    parameter int unsigned ADDR_W  = lutfab_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W  = lutfab_pkg::DEF_DATA_W
) (
    input  logic [N_CORES-1:0]        stb,
    input  logic [N_CORES*ADDR_W-1:0] addr_all,
    input  logic [N_CORES*DATA_W-1:0] data_all,
    output logic                      hit,
    output logic [ADDR_W-1:0]         m_addr,
    output logic [DATA_W-1:0]         m_data
);
    // AND-gate each source by its strobe, then OR all of them together
    always_comb begin
        hit    = 1'b0;
        m_addr = '0;
        m_data = '0;
        for (int s = 0; s < int'(N_CORES); s++) begin
            hit    = hit | stb[s];
            m_addr = m_addr | (addr_all[s*ADDR_W +: ADDR_W] & {ADDR_W{stb[s]}});
            m_data = m_data | (data_all[s*DATA_W +: DATA_W] & {DATA_W{stb[s]}});
        end
    end
endmodule

// File: rtl/lutfab_dpram.sv
module lutfab_dpram #(
    parameter int unsigned ADDR_W = lutfab_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W = lutfab_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

    // R1: with no write on the last edge and a steady address, the read word holds
    p_rd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(we) && $stable(raddr)) |=> $stable(rdata));
endmodule

// File: rtl/lutfab_target.sv
module lutfab_target #(
    parameter int unsigned N_CORES = lutfab_pkg::DEF_CORES,
    parameter int unsigned ADDR_W  = lutfab_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W  = lutfab_pkg::DEF_DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CORES-1:0]        stb_in,
    input  logic [N_CORES*ADDR_W-1:0] addr_all,
    input  logic [N_CORES*DATA_W-1:0] data_all,
    input  logic                      mask_we,
    input  logic [N_CORES-1:0]        mask_val,
    input  logic                      evt_clr,
    output logic                      evt_flag,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data
);
    typedef struct packed {
        logic [N_CORES-1:0] mask;
        logic               flag;
    } tgt_state_t;

    tgt_state_t        st_d, st_q;
    logic              hit;
    logic [ADDR_W-1:0] m_addr;
    logic [DATA_W-1:0] m_data;
    logic [N_CORES-1:0] gated_stb;

    assign gated_stb = stb_in & st_q.mask;

    lutfab_merge #(.N_CORES(N_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) merge_i (
        .stb      (gated_stb),
        .addr_all (addr_all),
        .data_all (data_all),
        .hit      (hit),
        .m_addr   (m_addr),
        .m_data   (m_data)
    );

    lutfab_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hit),
        .waddr (m_addr),
        .wdata (m_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_comb begin
        st_d = st_q;
        if (mask_we) st_d.mask = mask_val;
        if (hit)          st_d.flag = 1'b1;
        else if (evt_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= '1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_flag = st_q.flag;

    // R6: an accepted write raises the event flag
    p_evt_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> evt_flag);
    // R6: a clear with no write drops the flag
    p_evt_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && !hit) |=> !evt_flag);
    // R7: strobes that the mask rejects leave the flag untouched
    p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((stb_in & st_q.mask) == '0) && !evt_clr) |=> $stable(evt_flag));
endmodule

// File: rtl/lutfab_top.sv
module lutfab_top #(
    parameter int unsigned N_CORES = lutfab_pkg::DEF_CORES,
    parameter int unsigned ADDR_W  = lutfab_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W  = lutfab_pkg::DEF_DATA_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CORES*N_CORES-1:0]  src_stb,
    input  logic [N_CORES*ADDR_W-1:0]   src_addr,
    input  logic [N_CORES*DATA_W-1:0]   src_data,
    input  logic [N_CORES-1:0]          mask_we,
    input  logic [N_CORES*N_CORES-1:0]  mask_val,
    input  logic [N_CORES-1:0]          evt_clr,
    output logic [N_CORES-1:0]          evt_flag,
    input  logic [N_CORES*ADDR_W-1:0]   rd_addr,
    output logic [N_CORES*DATA_W-1:0]   rd_data
);
    logic [N_CORES-1:0] tgt_stb [N_CORES];

    for (genvar t = 0; t < int'(N_CORES); t++) begin : g_tgt
        for (genvar s = 0; s < int'(N_CORES); s++) begin : g_src
            assign tgt_stb[t][s] = src_stb[s*N_CORES + t];
        end

        lutfab_target #(.N_CORES(N_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) tgt_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .stb_in   (tgt_stb[t]),
            .addr_all (src_addr),
            .data_all (src_data),
            .mask_we  (mask_we[t]),
            .mask_val (mask_val[t*N_CORES +: N_CORES]),
            .evt_clr  (evt_clr[t]),
            .evt_flag (evt_flag[t]),
            .rd_addr  (rd_addr[t*ADDR_W +: ADDR_W]),
            .rd_data  (rd_data[t*DATA_W +: DATA_W])
        );
    end
endmodule

// File: tb/lutfab_top_tb_top.sv
module lutfab_top_tb_top;
    localparam int N  = 16;
    localparam int AW = 7;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N*N-1:0]  src_stb  = '0;
    logic [N*AW-1:0] src_addr = '0;
    logic [N*DW-1:0] src_data = '0;
    logic [N-1:0]    mask_we  = '0;
    logic [N*N-1:0]  mask_val = '0;
    logic [N-1:0]    evt_clr  = '0;
    logic [N-1:0]    evt_flag;
    logic [N*AW-1:0] rd_addr  = '0;
    logic [N*DW-1:0] rd_data;

    always #4 clk = ~clk;

    lutfab_top #(.N_CORES(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_stb(src_stb), .src_addr(src_addr),
        .src_data(src_data), .mask_we(mask_we), .mask_val(mask_val),
        .evt_clr(evt_clr), .evt_flag(evt_flag), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // behavioural reference
    logic [DW-1:0] mdl_mem [N][DEPTH];
    bit            mdl_vld [N][DEPTH];
    bit            mdl_flag [N];
    logic [N-1:0]  mdl_mask [N];
    logic [DW-1:0] exp_rd [N];
    bit            exp_rv [N];

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R8";
    bit done = 0;

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clr_in();
        src_stb = '0; mask_we = '0; evt_clr = '0;
    endtask

    task automatic put(int s, int t, int a, logic [DW-1:0] d);
        src_stb[s*N + t] = 1'b1;
        src_addr[s*AW +: AW] = AW'(a);
        src_data[s*DW +: DW] = d;
    endtask

    task automatic tick();
        for (int t = 0; t < N; t++) begin
            int ra = int'(rd_addr[t*AW +: AW]);
            exp_rd[t] = mdl_mem[t][ra];
            exp_rv[t] = mdl_vld[t][ra];
        end
        for (int t = 0; t < N; t++) begin
            bit hit = 0;
            logic [AW-1:0] a = '0;
            logic [DW-1:0] d = '0;
            for (int s = 0; s < N; s++) begin
                if (src_stb[s*N + t] && mdl_mask[t][s]) begin
                    hit = 1;
                    a = a | src_addr[s*AW +: AW];
                    d = d | src_data[s*DW +: DW];
                end
            end
            if (hit) begin
                mdl_mem[t][a] = d;
                mdl_vld[t][a] = 1;
                mdl_flag[t] = 1;
            end else if (evt_clr[t]) begin
                mdl_flag[t] = 0;
            end
            if (mask_we[t]) mdl_mask[t] = mask_val[t*N +: N];
        end
        @(posedge clk);
        @(negedge clk);
        for (int t = 0; t < N; t++) begin
            chk({cur_req, " flag"}, DW'(evt_flag[t]), DW'(mdl_flag[t]));
            if (exp_rv[t]) chk({cur_req, " read"}, rd_data[t*DW +: DW], exp_rd[t]);
        end
        clr_in();
    endtask

    task automatic read_at(int t, int a);
        rd_addr[t*AW +: AW] = AW'(a);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < N; t++) begin
            mdl_flag[t] = 0;
            mdl_mask[t] = '1;
            for (int a = 0; a < DEPTH; a++) mdl_vld[t][a] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: flags clear after reset
        for (int t = 0; t < N; t++) chk("R8 reset flag", DW'(evt_flag[t]), '0);

        // R2: source 0 broadcasts a fill to all targets
        cur_req = "R2";
        for (int a = 0; a < DEPTH; a++) begin
            for (int t = 0; t < N; t++) put(0, t, a, DW'(32'hA500_0000 + a * 3));
            tick();
        end
        for (int t = 0; t < N; t++) read_at(t, 5);
        tick();
        tick();

        // R6: clearing with no write drops the flags
        cur_req = "R6";
        evt_clr = '1;
        tick();

        // R3: every source writes the next target in the same cycle
        cur_req = "R3";
        for (int s = 0; s < N; s++) put(s, (s + 1) % N, 10 + s, DW'(32'h3000_0000 + s));
        for (int t = 0; t < N; t++) read_at(t, 10 + (t + N - 1) % N);
        tick();
        tick();
        evt_clr = '1;
        tick();

        // R4: collision data 2 to addr 2 and data 1 to addr 1 on target 5
        cur_req = "R4";
        put(1, 5, 2, 32'd2);
        put(2, 5, 1, 32'd1);
        read_at(5, 3);
        tick();
        tick();
        chk("R4 merged word at address 3", rd_data[5*DW +: DW], 32'd3);

        // R5: core 4 writes its own RAM
        cur_req = "R5";
        put(4, 4, 40, 32'hC0FF_EE04);
        read_at(4, 40);
        tick();
        tick();
        chk("R5 self write", rd_data[4*DW +: DW], 32'hC0FF_EE04);

        // R7: target 6 admits only source 0, then source 3 is blocked
        cur_req = "R7";
        evt_clr[6] = 1'b1;
        mask_we[6] = 1'b1;
        mask_val[6*N +: N] = 16'h0001;
        tick();
        put(3, 6, 20, 32'hBAD0_0003);
        read_at(6, 20);
        tick();
        chk("R7 blocked flag", DW'(evt_flag[6]), '0);
        tick();
        chk("R7 blocked data", rd_data[6*DW +: DW], DW'(32'hA500_0000 + 20 * 3));
        put(0, 6, 20, 32'h600D_0000);
        tick();
        tick();
        chk("R7 admitted data", rd_data[6*DW +: DW], 32'h600D_0000);

        // R6: write beats a clear in the same cycle
        cur_req = "R6";
        evt_clr[7] = 1'b1;
        put(9, 7, 30, 32'h7777_0009);
        tick();
        chk("R6 write wins over clear", DW'(evt_flag[7]), 32'd1);

        // R1 R4: random traffic with frequent overlaps
        cur_req = "R1";
        for (int c = 0; c < 3000; c++) begin
            for (int s = 0; s < N; s++) begin
                src_addr[s*AW +: AW] = AW'($urandom);
                src_data[s*DW +: DW] = $urandom;
                for (int t = 0; t < N; t++) src_stb[s*N + t] = ($urandom % 24) == 0;
            end
            for (int t = 0; t < N; t++) begin
                read_at(t, $urandom % DEPTH);
                evt_clr[t] = ($urandom % 6) == 0;
                if (($urandom % 40) == 0) begin
                    mask_we[t] = 1'b1;
                    mask_val[t*N +: N] = N'($urandom);
                end
            end
            tick();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule